// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset into a 20-bit physical byte address by pairing it with one of four 16-bit segment bases. The base is shifted up by one hex digit (four bits) and added to the offset; any carry past bit 19 is dropped, so addresses wrap within a 1 MiB space.

A request carries the offset and a two-bit code for the kind of pointer that supplied it. That code selects the default segment. A request can also set an override enable with a two-bit segment number, and the named segment is then used in place of the default. The four bases are loaded through a simple write port. The address and a valid flag come out of a register one cycle after the request.

Top module: `seg_addr_gen`

## Requirements
- R1: While reset is high, and on the cycle after it, `addr_vld` is 0 and `phys_addr` is 0. Reset sets all four segment bases to 0, so a request made right after reset returns its offset unchanged.
- R2: The address is (base × 16 + offset) taken modulo 2^20. With base 0000, offset FFFF gives 0FFFF and offset 0003 gives 00003. The low four bits of the address always equal the low four bits of the offset.
- R3: A carry out of bit 19 is discarded. For example, base FFFF with offset 0020 gives 00010.
- R4: Offset kind 0 (instruction pointer) uses the code segment (segment number 0) unless an override is active.
- R5: Offset kind 1 (source or destination index) uses the data segment (segment number 1) unless an override is active. When `req_ovr_en` is 0, the value of `req_ovr_seg` has no effect.
- R6: Offset kind 2 (stack or base pointer) uses the stack segment (segment number 2) unless an override is active.
- R7: Offset kind 3 (extra) uses the extra segment (segment number 3) unless an override is active.
- R8: When `req_ovr_en` is 1, the segment number in `req_ovr_seg` is used for every offset kind. The numbers are 0 code, 1 data, 2 stack, 3 extra.
- R9: `addr_vld` is 1 exactly on the cycle after a cycle with `req_vld` high. After a cycle with no request, `phys_addr` keeps its previous value.
- R10: A write to a segment base affects requests issued on the following cycle and later. A request made in the same cycle as the write uses the old base.
- R11: A write with `seg_wr_en` high changes only the base named by `seg_wr_sel`. The numbering is the same as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| seg_wr_en | input | 1 | Write strobe for a segment base |
| seg_wr_sel | input | 2 | Segment number to write (0 code, 1 data, 2 stack, 3 extra) |
| seg_wr_data | input | 16 | New segment base value |
| req_vld | input | 1 | Address request strobe |
| req_kind | input | 2 | Offset kind (0 instruction pointer, 1 index, 2 stack/base pointer, 3 extra) |
| req_ovr_en | input | 1 | Use `req_ovr_seg` in place of the default segment |
| req_ovr_seg | input | 2 | Override segment number |
| req_offset | input | 16 | Offset within the segment |
| addr_vld | output | 1 | Address valid, one cycle after the request |
| phys_addr | output | 20 | Physical byte address |

## Verification
There is one register between a request and its result. Each request is therefore driven on a falling edge and held through exactly one rising edge. `addr_vld` and `phys_addr` are checked on the following falling edge. On the idle cycle after a request, the checks confirm that `addr_vld` has dropped and `phys_addr` is unchanged. A segment write takes effect at the same rising edge as any request made alongside it, and the checks sample one edge after that. This shows the old base was used for that request and the new base for the next one.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

    localparam int SEG_W   = 16;
    localparam int OFS_W   = 16;
    localparam int SHIFT_W = 4;
    localparam int PA_W    = SEG_W + SHIFT_W;
    localparam int NUM_SEG = 4;
    localparam int SEL_W   = $clog2(NUM_SEG);

    typedef enum logic [SEL_W-1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_id_e;

    typedef enum logic [1:0] {
        KIND_IPTR  = 2'd0,
        KIND_INDEX = 2'd1,
        KIND_SPTR  = 2'd2,
        KIND_EXTRA = 2'd3
    } ofs_kind_e;

    typedef struct packed {
        logic             vld;
        ofs_kind_e        kind;
        logic             ovr_en;
        seg_id_e          ovr_seg;
        logic [OFS_W-1:0] offset;
    } addr_req_t;

    typedef struct packed {
        logic            vld;
        logic [PA_W-1:0] addr;
    } addr_rsp_t;

    // Default pairing of an offset kind with a segment.
    function automatic seg_id_e kind_to_seg(ofs_kind_e k);
        case (k)
            KIND_IPTR:  return SEG_CODE;
            KIND_INDEX: return SEG_DATA;
            KIND_SPTR:  return SEG_STACK;
            default:    return SEG_EXTRA;
        endcase
    endfunction

    // Base shifted by one hex digit plus zero-extended offset; carry out dropped.
    function automatic logic [PA_W-1:0] form_addr(logic [SEG_W-1:0] base,
                                                  logic [OFS_W-1:0] ofs);
        logic [PA_W-1:0] shifted;
        logic [PA_W-1:0] ext;
        shifted = {base, {SHIFT_W{1'b0}}};
        ext     = PA_W'(ofs);
        return shifted + ext;
    endfunction

endpackage

// File: rtl/seg_bank.sv
module seg_bank
    import seg_addr_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  seg_id_e                       wr_sel,
    input  logic [SEG_W-1:0]              wr_data,
    input  seg_id_e                       rd_sel,
    output logic [SEG_W-1:0]              rd_base
);

    logic [NUM_SEG-1:0][SEG_W-1:0] bases;

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        always_ff @(posedge clk) begin
            if (rst) begin
                bases[g] <= '0;
            end else if (wr_en && (wr_sel == seg_id_e'(g))) begin
                bases[g] <= wr_data;
            end
        end
    end

    // Read sees the value before any same-cycle write.
    assign rd_base = bases[rd_sel];

endmodule

// File: rtl/seg_pick.sv
module seg_pick
    import seg_addr_pkg::*;
(
    input  ofs_kind_e kind,
    input  logic      ovr_en,
    input  seg_id_e   ovr_seg,
    output seg_id_e   eff_seg
);

    always_comb begin
        if (ovr_en) begin
            eff_seg = ovr_seg;
        end else begin
            eff_seg = kind_to_seg(kind);
        end
    end

endmodule

// File: rtl/pa_stage.sv
module pa_stage
    import seg_addr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [SEG_W-1:0] base,
    input  logic [OFS_W-1:0] offset,
    output addr_rsp_t        rsp
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp <= '0;
        end else begin
            rsp.vld <= in_vld;
            if (in_vld) begin
                rsp.addr <= form_addr(base, offset);
            end
        end
    end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_addr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                seg_wr_en,
    input  logic [1:0]          seg_wr_sel,
    input  logic [SEG_W-1:0]    seg_wr_data,
    input  logic                req_vld,
    input  logic [1:0]          req_kind,
    input  logic                req_ovr_en,
    input  logic [1:0]          req_ovr_seg,
    input  logic [OFS_W-1:0]    req_offset,
    output logic                addr_vld,
    output logic [PA_W-1:0]     phys_addr
);

    addr_req_t        req;
    seg_id_e          eff_seg;
    logic [SEG_W-1:0] sel_base;
    addr_rsp_t        rsp;

    assign req.vld     = req_vld;
    assign req.kind    = ofs_kind_e'(req_kind);
    assign req.ovr_en  = req_ovr_en;
    assign req.ovr_seg = seg_id_e'(req_ovr_seg);
    assign req.offset  = req_offset;

    seg_pick u_pick (
        .kind    (req.kind),
        .ovr_en  (req.ovr_en),
        .ovr_seg (req.ovr_seg),
        .eff_seg (eff_seg)
    );

    seg_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (seg_wr_en),
        .wr_sel  (seg_id_e'(seg_wr_sel)),
        .wr_data (seg_wr_data),
        .rd_sel  (eff_seg),
        .rd_base (sel_base)
    );

    pa_stage u_stage (
        .clk    (clk),
        .rst    (rst),
        .in_vld (req.vld),
        .base   (sel_base),
        .offset (req.offset),
        .rsp    (rsp)
    );

    assign addr_vld  = rsp.vld;
    assign phys_addr = rsp.addr;

endmodule

// File: rtl/seg_addr_chk.sv
module seg_addr_chk
    import seg_addr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_vld,
    input  logic [1:0]       req_kind,
    input  logic             req_ovr_en,
    input  logic [1:0]       req_ovr_seg,
    input  logic [OFS_W-1:0] req_offset,
    input  seg_id_e          eff_seg,
    input  logic             addr_vld,
    input  logic [PA_W-1:0]  phys_addr
);

    p_reset_out_r1: assert property (@(posedge clk)
        rst |=> (!addr_vld && phys_addr == '0));

    p_low_nibble_r2: assert property (@(posedge clk) disable iff (rst)
        req_vld |=> (phys_addr[SHIFT_W-1:0] == $past(req_offset[SHIFT_W-1:0])));

    p_code_default_r4: assert property (@(posedge clk) disable iff (rst)
        (!req_ovr_en && req_kind == 2'd0) |-> eff_seg == SEG_CODE);

    p_data_default_r5: assert property (@(posedge clk) disable iff (rst)
        (!req_ovr_en && req_kind == 2'd1) |-> eff_seg == SEG_DATA);

    p_stack_default_r6: assert property (@(posedge clk) disable iff (rst)
        (!req_ovr_en && req_kind == 2'd2) |-> eff_seg == SEG_STACK);

    p_extra_default_r7: assert property (@(posedge clk) disable iff (rst)
        (!req_ovr_en && req_kind == 2'd3) |-> eff_seg == SEG_EXTRA);

    p_override_r8: assert property (@(posedge clk) disable iff (rst)
        req_ovr_en |-> (eff_seg == seg_id_e'(req_ovr_seg)));

    p_valid_follows_r9: assert property (@(posedge clk) disable iff (rst)
        req_vld |=> addr_vld);

    p_valid_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !req_vld |=> !addr_vld);

    p_hold_addr_r9: assert property (@(posedge clk) disable iff (rst)
        (!req_vld && !$past(rst)) |=> $stable(phys_addr));

endmodule

bind seg_addr_gen seg_addr_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_vld     (req_vld),
    .req_kind    (req_kind),
    .req_ovr_en  (req_ovr_en),
    .req_ovr_seg (req_ovr_seg),
    .req_offset  (req_offset),
    .eff_seg     (eff_seg),
    .addr_vld    (addr_vld),
    .phys_addr   (phys_addr)
);

// File: tb/seg_addr_gen_bench.sv
module seg_addr_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 12;

    // {kind, ovr_en, ovr_seg, offset, expected address}
    typedef struct packed {
        logic [1:0]  kind;
        logic        ovr_en;
        logic [1:0]  ovr_seg;
        logic [15:0] offset;
        logic [19:0] exp;
    } vec_t;

    // Bases: code 0000, data 1234, stack ABCD, extra FFFF
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 1'b0, 2'd0, 16'hFFFF, 20'h0FFFF},   // R4 R2
        '{2'd0, 1'b0, 2'd0, 16'h0003, 20'h00003},   // R4 R2
        '{2'd1, 1'b0, 2'd0, 16'h0010, 20'h12350},   // R5
        '{2'd2, 1'b0, 2'd0, 16'h0100, 20'hABDD0},   // R6
        '{2'd3, 1'b0, 2'd0, 16'h0020, 20'h00010},   // R7 R3
        '{2'd3, 1'b0, 2'd0, 16'h000F, 20'hFFFFF},   // R7 R2
        '{2'd0, 1'b1, 2'd1, 16'h0001, 20'h12341},   // R8
        '{2'd1, 1'b1, 2'd2, 16'hFFFF, 20'hBBCCF},   // R8
        '{2'd2, 1'b1, 2'd3, 16'h8000, 20'h07FF0},   // R8 R3
        '{2'd3, 1'b1, 2'd0, 16'h1234, 20'h01234},   // R8
        '{2'd1, 1'b0, 2'd2, 16'h0000, 20'h12340},   // R5 override field ignored
        '{2'd2, 1'b0, 2'd0, 16'hFFFF, 20'hBBCCF}    // R6
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        seg_wr_en = 1'b0;
    logic [1:0]  seg_wr_sel = '0;
    logic [15:0] seg_wr_data = '0;
    logic        req_vld = 1'b0;
    logic [1:0]  req_kind = '0;
    logic        req_ovr_en = 1'b0;
    logic [1:0]  req_ovr_seg = '0;
    logic [15:0] req_offset = '0;
    logic        addr_vld;
    logic [19:0] phys_addr;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_addr_gen u_seg_addr_gen (
        .clk         (clk),
        .rst         (rst),
        .seg_wr_en   (seg_wr_en),
        .seg_wr_sel  (seg_wr_sel),
        .seg_wr_data (seg_wr_data),
        .req_vld     (req_vld),
        .req_kind    (req_kind),
        .req_ovr_en  (req_ovr_en),
        .req_ovr_seg (req_ovr_seg),
        .req_offset  (req_offset),
        .addr_vld    (addr_vld),
        .phys_addr   (phys_addr)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_seg(logic [1:0] sel, logic [15:0] val);
        seg_wr_en = 1'b1; seg_wr_sel = sel; seg_wr_data = val;
        @(posedge clk);
        @(negedge clk);
        seg_wr_en = 1'b0;
    endtask

    // Drive for one edge; return at the next falling edge with the result due.
    task automatic issue(logic [1:0] k, logic oe, logic [1:0] os, logic [15:0] ofs);
        req_vld = 1'b1; req_kind = k; req_ovr_en = oe; req_ovr_seg = os; req_offset = ofs;
        @(posedge clk);
        @(negedge clk);
        req_vld = 1'b0; req_ovr_en = 1'b0; req_offset = 16'h5A5A;
    endtask

    task automatic idle_check(string tag, logic [19:0] held);
        @(posedge clk);
        @(negedge clk);
        check({tag, " valid low"}, 32'(addr_vld), 32'd0);
        check({tag, " address held"}, 32'(phys_addr), 32'(held));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset valid", 32'(addr_vld), 32'd0);
        check("R1 reset addr", 32'(phys_addr), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", 32'(addr_vld), 32'd0);
        issue(2'd1, 1'b0, 2'd0, 16'h0042);
        check("R1 data base zero", 32'(phys_addr), 32'h00042);
        issue(2'd3, 1'b0, 2'd0, 16'h0077);
        check("R1 extra base zero", 32'(phys_addr), 32'h00077);

        write_seg(2'd0, 16'h0000);
        write_seg(2'd1, 16'h1234);
        write_seg(2'd2, 16'hABCD);
        write_seg(2'd3, 16'hFFFF);

        for (int i = 0; i < NVEC; i++) begin
            issue(VECS[i].kind, VECS[i].ovr_en, VECS[i].ovr_seg, VECS[i].offset);
            check($sformatf("R2 vec%0d valid (R9)", i), 32'(addr_vld), 32'd1);
            check($sformatf("R2 vec%0d addr R4-R8 table", i), 32'(phys_addr), 32'(VECS[i].exp));
            idle_check($sformatf("R9 vec%0d", i), VECS[i].exp);
        end

        // R10: write code base and request with the same edge
        seg_wr_en = 1'b1; seg_wr_sel = 2'd0; seg_wr_data = 16'h0100;
        req_vld = 1'b1; req_kind = 2'd0; req_ovr_en = 1'b0; req_offset = 16'h0000;
        @(posedge clk);
        @(negedge clk);
        seg_wr_en = 1'b0; req_vld = 1'b0;
        check("R10 same-cycle old base", 32'(phys_addr), 32'h00000);
        issue(2'd0, 1'b0, 2'd0, 16'h0000);
        check("R10 next-cycle new base", 32'(phys_addr), 32'h01000);

        // R11: other bases untouched
        issue(2'd1, 1'b0, 2'd0, 16'h0000);
        check("R11 data untouched", 32'(phys_addr), 32'h12340);
        issue(2'd2, 1'b0, 2'd0, 16'h0000);
        check("R11 stack untouched", 32'(phys_addr), 32'hABCD0);
        issue(2'd3, 1'b0, 2'd0, 16'h0000);
        check("R11 extra untouched", 32'(phys_addr), 32'hFFFF0);

        // R1: reset mid-run clears bases
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid-run reset addr", 32'(phys_addr), 32'd0);
        issue(2'd2, 1'b0, 2'd0, 16'h0005);
        check("R1 stack cleared", 32'(phys_addr), 32'h00005);
        issue(2'd1, 1'b1, 2'd0, 16'h0009);
        check("R1 code cleared via R8", 32'(phys_addr), 32'h00009);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule